// File: doc/BRIEF.md
# SMBus Clock-Control Register Slave

This block is the serial configuration port of a clock generator. It listens on a two-wire SMBus link (clock and data, both synchronised into the system clock domain). It accepts byte and block write and read transactions aimed at its device address, and it keeps a small bank of 8-bit control registers. The contents of every register are presented in parallel on `ctrl_o`, so the clock-generator logic can use them directly. The slave pulls the data line low through an open-drain enable, both to acknowledge and to return read data.

The command byte chooses the access type. With its top bit set, the lower seven bits address one register, and a single data byte is transferred. With the top bit clear, the access is a counted block transfer that always begins at register index 4 and moves upward. Lower indices belong to other devices that share the address. Two register slots are read-only: one reflects the parallel `strap_i` input, and one holds a fixed signature.

Top module: `smbr_top`

## Requirements
- R1: Only the address byte D2h (write) or D3h (read) is acknowledged. Any other address byte gets no acknowledge, and the slave stays off the data line until the next START.
- R2: In a write with command bit 7 = 1, bits 6:0 of the command select the register index. The first data byte is stored there. Any further data bytes in the same transaction are acknowledged and discarded.
- R3: In a read with command bit 7 = 1 (command, repeated START, D3h), the slave returns the register at the indexed location, most significant bit first.
- R4: A write with command 00h is followed by a count byte and then data bytes. The data bytes go to indices 4, 5, 6 and so on, in ascending order.
- R5: A read with command 00h returns first a count byte equal to the number of registers (8). It then returns the registers from index 4 upward, for as long as the master acknowledges, and stops after the master's NACK.
- R6: Index 5 reads the current `strap_i` value, and index 8 reads 80h. Writes to either index leave them unchanged.
- R7: The implemented indices are 4 to 11. A write to any other index changes no register, and a read from any other index returns 00h.
- R8: A STOP or START arriving in the middle of a byte ends the transaction at once. Bytes that were already complete stay written, and the partial byte is lost.
- R9: After reset, the registers hold 02h at index 4, 0Bh at index 6, FFh at index 7, B0h at index 9, FFh at index 10 and 00h at index 11.
- R10: Every address, command, count and data byte received in an addressed transaction is acknowledged by holding SDA low during the ninth SCL pulse. SDA changes only while SCL is low.
- R11: `ctrl_o[8k+7:8k]` always shows the register at index 4+k, for k = 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line, as seen at the pad |
| sda_i | input | 1 | SMBus data line, as seen at the pad |
| strap_i | input | 8 | Latched strap value, readable at index 5 |
| sda_oe | output | 1 | 1 = pull the data line low |
| ctrl_o | output | 64 | Parallel view of all registers, index 4 at the low byte |

## Verification
A wrong byte pointer or a wrong state in the protocol engine shows up at the ports in one of two ways. The ninth-bit acknowledge of that same byte is missing, or the wrong register changes on `ctrl_o` within a few system clocks of the eighth SCL rise. The bench sweeps byte writes and byte reads over every index from 0 to 15 and over index 127. It also runs full and truncated block transfers, and compares each result with a register model it keeps itself. Aborted bytes and foreign addresses are checked by reading `ctrl_o` right after the bus goes idle, before any further transaction can hide the effect.

// File: rtl/smbr_pkg.sv
package smbr_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TACK} st_e;
  typedef enum logic [1:0] {RL_ADDR, RL_CMD, RL_CNT, RL_DATA} role_e;
endpackage

// File: rtl/smbr_sync.sv
module smbr_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q;
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b1;
        sync_o[i] <= 1'b1;
        prev_o[i] <= 1'b1;
      end else begin
        meta_q[i] <= raw_i[i];
        sync_o[i] <= meta_q[i];
        prev_o[i] <= sync_o[i];
      end
    end
  end
endmodule

// File: rtl/smbr_regbank.sv
module smbr_regbank #(
  parameter int                    NUM_REG   = 8,
  parameter int                    BASE_IDX  = 4,
  parameter int                    STRAP_REL = 1,
  parameter int                    SIG_REL   = 4,
  parameter logic [7:0]            SIG_VAL   = 8'h80,
  parameter logic [NUM_REG*8-1:0]  RST_VAL   = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [6:0]           wr_idx,
  input  logic [7:0]           wr_data,
  input  logic [6:0]           rd_idx,
  output logic [7:0]           rd_data,
  input  logic [7:0]           strap_i,
  output logic [NUM_REG*8-1:0] regs_o
);
  logic [7:0] val [NUM_REG];

  for (genvar k = 0; k < NUM_REG; k++) begin : g_reg
    localparam logic [6:0] IDX = 7'(BASE_IDX + k);
    if (k == STRAP_REL) begin : g_strap
      assign val[k] = strap_i;
    end else if (k == SIG_REL) begin : g_sig
      assign val[k] = SIG_VAL;
    end else begin : g_rw
      logic [7:0] q;
      logic       hit;
      assign hit = wr_en && (wr_idx == IDX);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= RST_VAL[k*8 +: 8];
        else if (hit) q <= wr_data;
      end
      assign val[k] = q;
    end
    assign regs_o[k*8 +: 8] = val[k];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int k = 0; k < NUM_REG; k++)
      if (rd_idx == 7'(BASE_IDX + k)) rd_data = val[k];
  end
endmodule

// File: rtl/smbr_top.sv
module smbr_top
  import smbr_pkg::*;
#(
  parameter logic [6:0]           DEV_ADDR  = 7'h69,
  parameter int                   NUM_REG   = 8,
  parameter int                   BASE_IDX  = 4,
  parameter int                   STRAP_REL = 1,
  parameter int                   SIG_REL   = 4,
  parameter logic [7:0]           SIG_VAL   = 8'h80,
  parameter logic [NUM_REG*8-1:0] RST_VAL   = 64'h00FF_B000_FF0B_0002
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic [7:0]           strap_i,
  output logic                 sda_oe,
  output logic [NUM_REG*8-1:0] ctrl_o
);
  localparam logic [6:0] BASE7 = 7'(BASE_IDX);
  localparam logic [7:0] CNT8  = 8'(NUM_REG);

  logic [1:0] s_now, s_prev;
  logic scl_s, sda_s, scl_q, sda_q;
  smbr_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i({scl_i, sda_i}),
    .sync_o(s_now), .prev_o(s_prev)
  );
  assign {scl_s, sda_s} = s_now;
  assign {scl_q, sda_q} = s_prev;

  logic start_det, stop_det, scl_rise, scl_fall;
  assign start_det = scl_s && scl_q && sda_q && !sda_s;
  assign stop_det  = scl_s && scl_q && !sda_q && sda_s;
  assign scl_rise  = scl_s && !scl_q;
  assign scl_fall  = !scl_s && scl_q;

  st_e        state, n_state;
  role_e      role, n_role;
  logic [3:0] cnt, n_cnt;
  logic [7:0] shreg, n_shreg;
  logic [6:0] ptr, n_ptr;
  logic       blk, n_blk, first, n_first, once, n_once, tx, n_tx, oe, n_oe;

  logic       wr_en;
  logic [7:0] rx_byte, rd_data, tx_byte;
  assign rx_byte = {shreg[6:0], sda_s};
  assign tx_byte = (blk && first) ? CNT8 : rd_data;

  smbr_regbank #(
    .NUM_REG(NUM_REG), .BASE_IDX(BASE_IDX), .STRAP_REL(STRAP_REL),
    .SIG_REL(SIG_REL), .SIG_VAL(SIG_VAL), .RST_VAL(RST_VAL)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr), .wr_data(rx_byte),
    .rd_idx(ptr), .rd_data(rd_data), .strap_i(strap_i), .regs_o(ctrl_o)
  );

  always_comb begin
    n_state = state; n_role = role; n_cnt = cnt; n_shreg = shreg;
    n_ptr = ptr; n_blk = blk; n_first = first; n_once = once;
    n_tx = tx; n_oe = oe; wr_en = 1'b0;
    if (start_det) begin
      n_state = ST_RX; n_role = RL_ADDR; n_cnt = '0; n_oe = 1'b0;
    end else if (stop_det) begin
      n_state = ST_IDLE; n_oe = 1'b0;
    end else begin
      unique case (state)
        ST_RX: if (scl_rise) begin
          n_shreg = rx_byte;
          n_cnt   = cnt + 4'd1;
          if (cnt == 4'd7) begin
            n_state = ST_ACK;
            unique case (role)
              RL_ADDR: begin
                if (rx_byte[7:1] == DEV_ADDR) begin
                  n_tx = rx_byte[0]; n_role = RL_CMD;
                end else begin
                  n_state = ST_IDLE;
                end
              end
              RL_CMD: begin
                n_blk   = !rx_byte[7];
                n_ptr   = rx_byte[7] ? rx_byte[6:0] : BASE7;
                n_role  = rx_byte[7] ? RL_DATA : RL_CNT;
                n_first = 1'b1; n_once = 1'b0;
              end
              RL_CNT: n_role = RL_DATA;
              default: begin
                wr_en  = blk || !once;
                n_once = 1'b1;
                if (blk) n_ptr = ptr + 7'd1;
              end
            endcase
          end
        end
        ST_ACK: if (scl_fall) begin
          if (cnt == 4'd8) begin
            n_oe = 1'b1; n_cnt = 4'd9;
          end else if (tx) begin
            n_state = ST_TX; n_shreg = tx_byte; n_oe = !tx_byte[7]; n_cnt = '0;
          end else begin
            n_state = ST_RX; n_oe = 1'b0; n_cnt = '0;
          end
        end
        ST_TX: if (scl_fall) begin
          if (cnt == 4'd7) begin
            n_state = ST_TACK; n_oe = 1'b0; n_cnt = '0;
          end else begin
            n_shreg = {shreg[6:0], 1'b0}; n_oe = !shreg[6]; n_cnt = cnt + 4'd1;
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            if (sda_s) n_state = ST_IDLE;
            else begin
              n_cnt = 4'd1;
              if (blk && first) n_first = 1'b0;
              else              n_ptr   = ptr + 7'd1;
            end
          end else if (scl_fall && cnt == 4'd1) begin
            n_state = ST_TX; n_shreg = tx_byte; n_oe = !tx_byte[7]; n_cnt = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; role <= RL_ADDR; cnt <= '0; shreg <= '0;
      ptr <= BASE7; blk <= 1'b1; first <= 1'b0; once <= 1'b0;
      tx <= 1'b0; oe <= 1'b0;
    end else begin
      state <= n_state; role <= n_role; cnt <= n_cnt; shreg <= n_shreg;
      ptr <= n_ptr; blk <= n_blk; first <= n_first; once <= n_once;
      tx <= n_tx; oe <= n_oe;
    end
  end

  assign sda_oe = oe;
endmodule

// File: rtl/smbr_chk.sv
module smbr_chk
  import smbr_pkg::*;
#(
  parameter int NUM_REG   = 8,
  parameter int STRAP_REL = 1,
  parameter int SIG_REL   = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 scl_s,
  input logic                 scl_q,
  input logic                 sda_oe,
  input logic                 stop_det,
  input logic                 wr_en,
  input st_e                  state,
  input logic [NUM_REG*8-1:0] ctrl_o
);
  function automatic logic [NUM_REG*8-1:0] rw_mask();
    logic [NUM_REG*8-1:0] m = '1;
    m[STRAP_REL*8 +: 8] = 8'h00;
    m[SIG_REL*8 +: 8]   = 8'h00;
    return m;
  endfunction
  localparam logic [NUM_REG*8-1:0] RWM = rw_mask();

  // R1: the line is left alone while no addressed transaction runs
  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !sda_oe);

  // R10: SDA moves only while SCL is low
  assert_sda_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q) |-> $stable(sda_oe));

  // R8: a STOP returns the engine to idle on the next cycle
  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> state == ST_IDLE);

  // R2: register writes happen only on a completed eighth bit, at an SCL rise
  assert_write_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (scl_s && !scl_q && state == ST_RX));

  // R8: writable registers hold unless a write is issued
  assert_reg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_o & RWM));
endmodule

bind smbr_top smbr_chk #(.NUM_REG(NUM_REG), .STRAP_REL(STRAP_REL), .SIG_REL(SIG_REL)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_q(scl_q), .sda_oe(sda_oe),
  .stop_det(stop_det), .wr_en(wr_en), .state(state), .ctrl_o(ctrl_o)
);

// File: tb/smbr_top_tb.sv
`timescale 1ns/1ps
module smbr_top_tb;
  localparam int T = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [7:0] strap = 8'h3C;
  logic sda_oe;
  logic [63:0] ctrl_o;
  logic sda_line;
  assign sda_line = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  smbr_top u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .strap_i(strap), .sda_oe(sda_oe), .ctrl_o(ctrl_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] mdl [8];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [7:0] mdl_rd(input int idx);
    if (idx < 4 || idx > 11) return 8'h00;
    if (idx == 5) return strap;
    if (idx == 8) return 8'h80;
    return mdl[idx-4];
  endfunction

  function automatic void mdl_wr(input int idx, input logic [7:0] v);
    if (idx >= 4 && idx <= 11 && idx != 5 && idx != 8) mdl[idx-4] = v;
  endfunction

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; w(T); m_scl = 1'b1; w(T); m_sda = 1'b0; w(T); m_scl = 1'b0; w(T);
  endtask
  task automatic bus_stop();
    m_sda = 1'b0; w(T); m_scl = 1'b1; w(T); m_sda = 1'b1; w(T);
  endtask
  task automatic send_bit(input logic b);
    m_sda = b; w(T); m_scl = 1'b1; w(2*T); m_scl = 1'b0; w(T);
  endtask
  task automatic recv_bit(output logic b);
    m_sda = 1'b1; w(T); m_scl = 1'b1; w(T); b = sda_line; w(T); m_scl = 1'b0; w(T);
  endtask
  task automatic send_byte(input logic [7:0] d, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    acked = !a;
  endtask
  task automatic recv_byte(input bit last, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(last);
  endtask

  task automatic check_ctrl(input string tag);
    for (int k = 0; k < 8; k++)
      chk(ctrl_o[k*8 +: 8] === mdl_rd(k+4), tag, ctrl_o[k*8 +: 8], mdl_rd(k+4));
  endtask

  task automatic wr_byte(input int idx, input logic [7:0] v);
    bit a0, a1, a2;
    bus_start();
    send_byte(8'hD2, a0); send_byte(8'h80 | 8'(idx), a1); send_byte(v, a2);
    bus_stop();
    chk(a0 && a1 && a2, "R10 ack on byte write", {a0, a1, a2}, 3'b111);
    mdl_wr(idx, v);
  endtask

  task automatic rd_byte(input int idx, output logic [7:0] v);
    bit a0, a1, a2;
    bus_start();
    send_byte(8'hD2, a0); send_byte(8'h80 | 8'(idx), a1);
    bus_start();
    send_byte(8'hD3, a2); recv_byte(1'b1, v);
    bus_stop();
    chk(a0 && a1 && a2, "R1 ack on byte read", {a0, a1, a2}, 3'b111);
  endtask

  logic [7:0] rv;
  bit ak;

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    mdl[0] = 8'h02; mdl[1] = 8'h00; mdl[2] = 8'h0B; mdl[3] = 8'hFF;
    mdl[4] = 8'h00; mdl[5] = 8'hB0; mdl[6] = 8'hFF; mdl[7] = 8'h00;
    w(5); rst_n = 1'b1; w(5);
    check_ctrl("R9 reset values");

    // R2 R3 R6 R7 sweep over indices 0..15 and 127
    for (int i = 0; i < 17; i++) begin
      int idx = (i == 16) ? 127 : i;
      wr_byte(idx, 8'(idx * 37 + 11));
      check_ctrl("R11 ctrl after byte write");
    end
    for (int i = 0; i < 17; i++) begin
      int idx = (i == 16) ? 127 : i;
      rd_byte(idx, rv);
      chk(rv === mdl_rd(idx), "R3 R6 R7 byte read", rv, mdl_rd(idx));
    end

    // R6 strap follows input
    strap = 8'hA5; w(4);
    rd_byte(5, rv);
    chk(rv === 8'hA5, "R6 strap read-back", rv, 8'hA5);

    // R2 extra data bytes in single-byte mode are discarded
    begin
      bit a0, a1, a2, a3;
      bus_start();
      send_byte(8'hD2, a0); send_byte(8'h86, a1); send_byte(8'h5E, a2); send_byte(8'h77, a3);
      bus_stop();
      mdl_wr(6, 8'h5E);
      chk(a3, "R2 extra byte acked", a3, 1);
      check_ctrl("R2 extra byte ignored");
    end

    // R4 block write, 8 bytes
    begin
      bit a;
      bus_start();
      send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h08, a);
      for (int k = 0; k < 8; k++) begin
        send_byte(8'(8'hC0 + k * 3), a);
        chk(a, "R10 block data ack", a, 1);
        mdl_wr(k + 4, 8'(8'hC0 + k * 3));
      end
      bus_stop();
      check_ctrl("R4 block write");
    end

    // R5 block read
    begin
      bit a0, a1, a2;
      bus_start();
      send_byte(8'hD2, a0); send_byte(8'h00, a1);
      bus_start();
      send_byte(8'hD3, a2);
      recv_byte(1'b0, rv);
      chk(rv === 8'd8, "R5 block count", rv, 8);
      for (int k = 0; k < 8; k++) begin
        recv_byte(k == 7, rv);
        chk(rv === mdl_rd(k + 4), "R5 block read data", rv, mdl_rd(k + 4));
      end
      bus_stop();
    end

    // R4 R8 block write stopped after 3 bytes
    begin
      bit a;
      bus_start();
      send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h08, a);
      for (int k = 0; k < 3; k++) begin
        send_byte(8'(8'h10 + k), a);
        mdl_wr(k + 4, 8'(8'h10 + k));
      end
      bus_stop();
      check_ctrl("R8 early stop in block write");
    end

    // R8 STOP in the middle of a data byte
    begin
      bit a;
      bus_start();
      send_byte(8'hD2, a); send_byte(8'h87, a);
      for (int k = 0; k < 4; k++) send_bit(1'b0);
      m_scl = 1'b0; w(T);
      bus_stop();
      check_ctrl("R8 stop mid-byte");
    end

    // R8 repeated START in the middle of a byte, then a clean write
    begin
      bit a;
      bus_start();
      send_byte(8'hD2, a); send_byte(8'h87, a);
      for (int k = 0; k < 3; k++) send_bit(1'b1);
      bus_start();
      send_byte(8'hD2, a); send_byte(8'h87, a); send_byte(8'h5A, a);
      bus_stop();
      mdl_wr(7, 8'h5A);
      check_ctrl("R8 start mid-byte");
    end

    // R1 foreign address is not acknowledged and writes nothing
    begin
      bit a0, a1, a2;
      bus_start();
      send_byte(8'hA4, a0); send_byte(8'h87, a1); send_byte(8'h00, a2);
      bus_stop();
      chk(!a0 && !a1 && !a2, "R1 foreign address nack", {a0, a1, a2}, 0);
      check_ctrl("R1 foreign address no write");
    end

    summary();
  end
endmodule